// File: doc/BRIEF.md
# Ternary Overlap-Sample Bit Decoder

This block turns four interleaved sample lanes back into a serial bit stream. Each lane comes from an integrator opened on its own quarter-phase of the sampling clock. A lane reports how many ones fell inside its window, and each window covers two bits: the one before it and the new one. Neighbouring windows share one bit, so a window whose two bits differ cannot tell a rising pair from a falling pair. The block settles that case from the bit already decided for the window just before it. The history passes from lane to lane inside a cycle, and from the last lane of one cycle to the first lane of the next.

A stream that toggles on every bit yields nothing but "differ" samples and carries no anchor. For that reason the block starts unlocked. It releases valid bits only from the first window whose two bits agree, and from then on every window decodes through the history chain. Each accepted core cycle gives four bits in time order, a per-lane valid mask, a lock flag and a one-cycle flag for an illegal sample code. All outputs are registered.

Top module: `ovl_ternary_decoder`

## Requirements
- R1: A lane code of 2'b00 (both bits zero) decodes to 0, and 2'b10 (both bits one) decodes to 1, whatever the previous bit was.
- R2: A lane code of 2'b01 (bits differ) decodes to the inverse of the bit decided for the window just before it. For lane k above 0, that window is lane k-1 of the same cycle.
- R3: A 2'b01 code on lane 0 is resolved against the lane 3 bit of the previous accepted cycle, and that bit is held in a register.
- R4: While unlocked, a cycle made only of 2'b01 codes gives dec_valid 4'b0000, dec_bits 4'b0000 and locked 0.
- R5: In the cycle that acquires lock, lanes before the first 2'b00 or 2'b10 code have dec_valid 0 and dec_bits 0. That lane and every later lane are valid, and locked becomes 1. dec_valid therefore always reads 0000, 1000, 1100, 1110 or 1111.
- R6: Once locked, every accepted cycle with only legal codes gives dec_valid 4'b1111 and the correct bits.
- R7: A code of 2'b11 on any lane is illegal. The next output has code_err 1 for that one cycle, dec_valid 0, dec_bits 0 and locked 0. Lock returns only through R5.
- R8: While in_valid is 0, no state changes. The next output has dec_valid 0, dec_bits 0, code_err 0 and locked unchanged, and the history bit survives the stall.
- R9: Outputs appear one clock after the inputs are sampled. dec_bits[0] holds the oldest bit (lane 0) and dec_bits[3] the newest bit (lane 3). The lane k code sits at lane_codes[2k+1:2k].
- R10: A synchronous active-high reset clears the lock and the history, and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one edge per four sample windows |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lane codes present this cycle; low stalls the block |
| lane_codes | input | 8 | Four 2-bit window codes, lane 0 in the low bits |
| dec_bits | output | 4 | Decoded bits, bit 0 oldest |
| dec_valid | output | 4 | Per-lane valid mask for dec_bits |
| locked | output | 1 | Decoder has acquired the stream |
| code_err | output | 1 | One-cycle flag for an illegal lane code |

## Verification
The bench places the first anchoring code on each lane position and checks that the valid mask starts exactly there. A design that mis-ordered the lanes would shift or invert that mask. Runs of "differ" codes across cycle borders and across stalls test the lane 3 to lane 0 carry. A carry that was lost or overwritten during a stall would flip the first bit of the next cycle. Illegal codes are injected while locked, followed by toggle-only cycles, to show that the block stays unlocked until a real anchor arrives. A stream of random bits, with stalls mixed in, checks steady-state decoding against the true transmitted bits.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef logic [1:0] tcode_t;

  localparam tcode_t CODE_LOW  = 2'b00;
  localparam tcode_t CODE_MID  = 2'b01;
  localparam tcode_t CODE_HIGH = 2'b10;
  localparam tcode_t CODE_BAD  = 2'b11;

  // The window has two equal bits, so the new bit is known on its own.
  function automatic logic code_is_anchor(input tcode_t c);
    return (c == CODE_LOW) || (c == CODE_HIGH);
  endfunction

  function automatic logic code_is_illegal(input tcode_t c);
    return c == CODE_BAD;
  endfunction

  // New bit of a window, given the bit decided just before it.
  function automatic logic resolve_bit(input tcode_t c, input logic prev);
    case (c)
      CODE_LOW:  return 1'b0;
      CODE_HIGH: return 1'b1;
      CODE_MID:  return ~prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ovl_lane_resolve.sv
module ovl_lane_resolve
  import ovl_pkg::*;
(
  input  tcode_t code,
  input  logic   prev_bit,
  input  logic   prev_known,
  output logic   new_bit,
  output logic   new_known,
  output logic   bad
);

  always_comb begin
    bad       = code_is_illegal(code);
    new_bit   = resolve_bit(code, prev_bit);
    new_known = !bad && (code_is_anchor(code) || prev_known);
  end

endmodule

// File: rtl/ovl_lane_chain.sv
module ovl_lane_chain
  import ovl_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CW   = 2 * LANES
) (
  input  logic [CW-1:0]    codes,
  input  logic             carry_bit,
  input  logic             carry_known,
  output logic [LANES-1:0] bits,
  output logic [LANES-1:0] known,
  output logic             any_bad,
  output logic             tail_bit,
  output logic             tail_known
);

  logic [LANES:0]   link_bit;
  logic [LANES:0]   link_known;
  logic [LANES-1:0] lane_bad;

  assign link_bit[0]   = carry_bit;
  assign link_known[0] = carry_known;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tcode_t lane_code;
    assign lane_code = codes[2*g +: 2];

    ovl_lane_resolve u_res (
      .code       (lane_code),
      .prev_bit   (link_bit[g]),
      .prev_known (link_known[g]),
      .new_bit    (bits[g]),
      .new_known  (known[g]),
      .bad        (lane_bad[g])
    );

    assign link_bit[g+1]   = bits[g];
    assign link_known[g+1] = known[g];

    // R2 / R3: a differing window flips the bit of the window before it.
    always_comb begin
      if (lane_code == CODE_MID && link_known[g]) begin
        p_mid_flip_r2: assert (bits[g] != link_bit[g]);
      end
    end
  end

  assign any_bad    = |lane_bad;
  assign tail_bit   = link_bit[LANES];
  assign tail_known = link_known[LANES];

endmodule

// File: rtl/ovl_lock_ctrl.sv
module ovl_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic any_bad,
  input  logic tail_bit,
  input  logic tail_known,
  output logic locked_q,
  output logic hist_bit_q,
  output logic lock_gain,
  output logic lock_lost
);

  logic clean_step;
  assign clean_step = step && !any_bad;
  assign lock_gain  = clean_step && !locked_q && tail_known;
  assign lock_lost  = step && any_bad && locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q   <= 1'b0;
      hist_bit_q <= 1'b0;
    end else if (step) begin
      if (any_bad) begin
        locked_q   <= 1'b0;
        hist_bit_q <= 1'b0;
      end else begin
        locked_q   <= tail_known;
        hist_bit_q <= tail_bit;
      end
    end
  end

  // R7: lock is only regained through a clean cycle.
  p_relock_needs_clean_r7: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && !clean_step) |=> !locked_q);

  // R8: a stall leaves history and lock untouched.
  p_stall_holds_hist_r8: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(hist_bit_q) && $stable(locked_q));

  // R7: an illegal code clears the lock.
  p_bad_clears_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (step && any_bad) |=> !locked_q);

endmodule

// File: rtl/ovl_ternary_decoder.sv
module ovl_ternary_decoder
  import ovl_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CW   = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CW-1:0]    lane_codes,
  output logic [LANES-1:0] dec_bits,
  output logic [LANES-1:0] dec_valid,
  output logic             locked,
  output logic             code_err
);

  logic [LANES-1:0] chain_bits;
  logic [LANES-1:0] chain_known;
  logic             any_bad;
  logic             tail_bit;
  logic             tail_known;
  logic             locked_q;
  logic             hist_bit_q;
  logic             lock_gain;
  logic             lock_lost;

  ovl_lane_chain #(.LANES(LANES)) u_chain (
    .codes       (lane_codes),
    .carry_bit   (hist_bit_q),
    .carry_known (locked_q),
    .bits        (chain_bits),
    .known       (chain_known),
    .any_bad     (any_bad),
    .tail_bit    (tail_bit),
    .tail_known  (tail_known)
  );

  ovl_lock_ctrl u_lock (
    .clk        (clk),
    .rst        (rst),
    .step       (in_valid),
    .any_bad    (any_bad),
    .tail_bit   (tail_bit),
    .tail_known (tail_known),
    .locked_q   (locked_q),
    .hist_bit_q (hist_bit_q),
    .lock_gain  (lock_gain),
    .lock_lost  (lock_lost)
  );

  logic [LANES-1:0] valid_d;
  assign valid_d = (in_valid && !any_bad) ? chain_known : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_bits  <= '0;
      dec_valid <= '0;
      code_err  <= 1'b0;
    end else begin
      dec_bits  <= chain_bits & valid_d;
      dec_valid <= valid_d;
      code_err  <= in_valid && any_bad;
    end
  end

  assign locked = locked_q;

  // R10: the cycle after reset shows an idle, unlocked block.
  p_reset_idle_r10: assert property (@(posedge clk)
    $past(rst) |-> (!locked && dec_valid == '0 && !code_err && dec_bits == '0));

  // R7: the error flag comes with an empty mask and no lock.
  p_err_clears_r7: assert property (@(posedge clk) disable iff (rst)
    code_err |-> (!locked && dec_valid == '0));

  // R5: valid lanes exist only under lock.
  p_valid_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (|dec_valid) |-> locked);

  // R5: the mask is one run that ends at the newest lane.
  p_valid_contig_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dec_valid ^ {dec_valid[LANES-2:0], 1'b0}) && (dec_valid == '0 || dec_valid[LANES-1]));

  // R6: a locked, clean cycle gives a full mask.
  p_full_when_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && locked && !any_bad) |=> (dec_valid == '1 && locked));

  // R8: a stall gives an empty output and no error.
  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (dec_valid == '0 && !code_err && dec_bits == '0));

  // R5: a lock gain shows up as a nonempty mask.
  p_gain_shows_r5: assert property (@(posedge clk) disable iff (rst)
    lock_gain |=> (locked && dec_valid != '0));

  // R7: losing lock raises the error flag.
  p_lost_flags_r7: assert property (@(posedge clk) disable iff (rst)
    lock_lost |=> code_err);

endmodule

// File: tb/ovl_ternary_decoder_tb.sv
module ovl_ternary_decoder_tb_top;

  typedef struct {
    logic [3:0] bits;
    logic [3:0] valid;
    logic       lck;
    logic       err;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] lane_codes = 8'h00;
  logic [3:0] dec_bits;
  logic [3:0] dec_valid;
  logic       locked;
  logic       code_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  exp_t sb[$];

  // Reference state kept as "true line bits", not as decoder registers.
  bit m_locked = 0;
  bit m_prev   = 0;
  bit line_prev = 0;

  always #5 clk = ~clk;

  ovl_ternary_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_codes(lane_codes),
    .dec_bits(dec_bits), .dec_valid(dec_valid), .locked(locked), .code_err(code_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Count-of-ones view: a window holding one 1 means the new bit differs.
  task automatic drive(input logic [7:0] codes, input bit v, input string req);
    exp_t e;
    bit known;
    bit p;
    bit bad;
    @(negedge clk);
    in_valid   = v;
    lane_codes = codes;
    e.req = req; e.bits = 0; e.valid = 0; e.err = 0;
    bad = 0;
    for (int k = 0; k < 4; k++) if (codes[2*k +: 2] == 2'b11) bad = 1;
    if (!v) begin
      e.lck = m_locked;
    end else if (bad) begin
      m_locked = 0; m_prev = 0; e.lck = 0; e.err = 1;
    end else begin
      known = m_locked;
      p = m_prev;
      for (int k = 0; k < 4; k++) begin
        int ones;
        bit nb;
        ones = codes[2*k +: 2];
        if (ones == 1) nb = !p;
        else begin nb = (ones == 2); known = 1; end
        e.valid[k] = known;
        e.bits[k]  = known ? nb : 1'b0;
        p = nb;
      end
      m_locked = known;
      m_prev = p;
      e.lck = known;
    end
    sb.push_back(e);
  endtask

  // Build window codes from four fresh line bits (bit 0 sent first).
  task automatic send_bits(input logic [3:0] nb, input string req);
    logic [7:0] c;
    bit p;
    p = line_prev;
    for (int k = 0; k < 4; k++) begin
      c[2*k +: 2] = 2'(int'(p) + int'(nb[k]));
      p = nb[k];
    end
    line_prev = p;
    drive(c, 1'b1, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    m_locked = 0; m_prev = 0;
    check(locked == 0 && dec_valid == 0 && code_err == 0 && dec_bits == 0,
          "R10", "reset outputs", {dec_bits, dec_valid, locked, code_err}, 0);
  endtask

  // Scoreboard monitor: one expected item per clock after it was pushed.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(dec_valid == e.valid, e.req, "dec_valid", dec_valid, e.valid);
        check(dec_bits == e.bits, e.req, "dec_bits", dec_bits, e.bits);
        check(locked == e.lck, e.req, "locked", locked, e.lck);
        check(code_err == e.err, e.req, "code_err", code_err, e.err);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    do_reset();

    // R4: toggle-only cycles stay unlocked.
    drive(8'b01_01_01_01, 1, "R4");
    drive(8'b01_01_01_01, 1, "R4");
    // R5: first anchor on lane 2 (high): mask 1100, bits lane2=1 lane3=0.
    drive(8'b01_10_01_01, 1, "R5");
    // R3: lane 0 differs from previous lane 3 (0) -> 1.
    drive(8'b01_01_01_01, 1, "R3");
    // R1: anchors ignore history.
    drive(8'b10_00_10_00, 1, "R1");
    drive(8'b00_00_10_10, 1, "R1");
    // R8: stall keeps history, then lane 0 differ uses it.
    drive(8'b11_11_11_11, 0, "R8");
    drive(8'b00_00_00_00, 0, "R8");
    drive(8'b01_01_01_01, 1, "R3");
    // R7: illegal code drops lock, toggles do not relock.
    drive(8'b01_11_01_01, 1, "R7");
    drive(8'b01_01_01_01, 1, "R7");
    // R5: anchor on lane 3 only, then on lane 0.
    drive(8'b10_01_01_01, 1, "R5");
    drive(8'b01_01_01_01, 1, "R6");
    drive(8'b11_00_00_00, 1, "R7");
    drive(8'b01_01_01_00, 1, "R5");
    drive(8'b01_00_01_01, 1, "R2");

    // R10: reset while locked.
    drive(8'b00_00_00_00, 1, "R6");
    do_reset();
    drive(8'b01_01_01_01, 1, "R10");

    // R6 / R9: random line bits with stalls; windows built from true bits.
    line_prev = 0;
    send_bits(4'b0000, "R5");
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 7) == 0) drive(8'($urandom), 0, "R8");
      else send_bits(4'($urandom), "R9");
    end
    // R2: alternating line while locked keeps decoding.
    for (int i = 0; i < 4; i++) send_bits(line_prev ? 4'b1010 : 4'b0101, "R2");

    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule